// File: doc/BRIEF.md
# Standby Power-On Wake Controller

This block decides when to request main power by pulling an active-low power-on pin, which it either drives low or releases to float. The decision rests on an 8-bit control register held in the battery domain, a level that says whether the standby supply is present, a pulse marking a power-on reset of the standby supply, a pulse from the second-alarm comparator, and a main-power-good acknowledgement. The alarm comparison, the oscillator and the analog supply sensing sit outside and reach the block as clean digital signals.

The block's main job is the remembered wake. If the second alarm fires while the standby supply is absent and the remember enable is set, the block records the event and raises the power-on request as soon as standby power returns. It does not care whether the separate alarm wake enable is set. A standby power-on reset can also carry a policy. One policy forces the machine on. The other keeps it off, and the keep-off policy wins if both are set. A conflicting setting is recorded in a sticky flag.

A four-state machine holds the sequencing. `ST_IDLE` is released with nothing pending. `ST_WAIT_STBY` has an alarm remembered and standby absent. `ST_DRIVE` drives the pin low until main power is good. `ST_HOLD_OFF` is the pin held released after a keep-off reset. The named transitions are:
- arm: IDLE to WAIT_STBY, when the record is set and standby is absent.
- wake: IDLE or WAIT_STBY to DRIVE, when the record is set and standby is present.
- abort: WAIT_STBY to IDLE, when the record has been cleared.
- force_on: any state to DRIVE, on a reset with only the force-on bit set.
- force_off: any state to HOLD_OFF, on a reset with the keep-off bit set.
- ack: DRIVE to IDLE, when main power is good.
- unhold: HOLD_OFF to IDLE, when standby is lost or the host writes.

Top module: `standby_wake_ctrl`

## Requirements
- R1: After a battery reset, `host_rdata` reads 0x00 and `pwr_on_drive`, `alarm_pending` and `cfg_conflict` are all 0.
- R2: A host write stores bit 0 (remember enable), bit 1 (keep-off on reset), bit 2 (force-on on reset) and bit 7 (crystal load select) on the write edge, and they read back at the same positions. Bits 6:3 always read 0, whatever was written.
- R3: `alarm2_hit` sampled with bit 0 set and `stby_present` low sets `alarm_pending` on that edge. With bit 0 clear, or with `stby_present` high, the pulse leaves `alarm_pending` unchanged.
- R4: While `alarm_pending` is 1 and `stby_present` is 0, `pwr_on_drive` stays 0. On the first edge where `stby_present` is 1 with the record already held, `pwr_on_drive` becomes 1.
- R5: `pwr_on_drive` stays 1 until `main_pwr_good` is sampled high, unless a reset policy applies on that edge. On that edge it returns to 0 and `alarm_pending` clears.
- R6: A host write with bit 0 at 0 clears `alarm_pending` on the write edge. A waiting wake is then abandoned, and `pwr_on_drive` stays 0 when standby returns.
- R7: `stby_por` sampled with bit 2 set and bit 1 clear makes `pwr_on_drive` 1 on that edge.
- R8: `stby_por` sampled with bit 1 set makes `pwr_on_drive` 0 on that edge, even if it was driving. It stays 0 until `stby_present` is sampled low or the host writes, and only then may a held record wake the machine.
- R9: When bits 1 and 2 are both set, the keep-off policy applies to `stby_por`. `cfg_conflict` becomes 1 on the edge of the write that sets both bits, and it stays 1 until a battery reset.
- R10: `stby_por` never changes the register contents or `alarm_pending`.
- R11: Bit 7 is only stored. Its value changes no drive or record behaviour.
- R12: `stby_por` with neither bit 1 nor bit 2 set leaves `pwr_on_drive` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Battery-domain clock |
| batt_rst_n | input | 1 | Battery-domain reset, active low, asynchronous |
| stby_present | input | 1 | Standby supply present level |
| stby_por | input | 1 | Standby supply power-on-reset pulse |
| alarm2_hit | input | 1 | Second-alarm match pulse |
| main_pwr_good | input | 1 | Main power good acknowledgement |
| host_wr | input | 1 | Host register write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register read-back value |
| pwr_on_drive | output | 1 | 1 drives the power-on pin low, 0 lets it float |
| alarm_pending | output | 1 | Alarm-passed-during-power-loss record |
| cfg_conflict | output | 1 | Sticky flag for both reset policies set |

## Verification
The bench goes after the alarm that fires while standby is present. A design that skipped the supply check would record it and wake the machine for no reason. It checks that a remembered alarm does not drive before standby returns, which an ungated design would get wrong by driving into a dead supply. It checks a host clear of the remember bit during the wait, where a stale record would still wake the machine. It also fires a keep-off reset while the pin is driven and with a record held. A design that reset the record on that reset would lose the wake after the hold, and one that let force-on win under conflict would power up against policy.

// File: rtl/swk_pkg.sv
package swk_pkg;

    localparam int CFG_W    = 8;
    localparam int REM_BIT  = 0;
    localparam int OFF_BIT  = 1;
    localparam int ON_BIT   = 2;
    localparam int XTAL_BIT = 7;

    localparam logic [CFG_W-1:0] KEEP_MASK =
        (CFG_W'(1) << REM_BIT) | (CFG_W'(1) << OFF_BIT) |
        (CFG_W'(1) << ON_BIT)  | (CFG_W'(1) << XTAL_BIT);

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_STBY = 2'd1,
        ST_DRIVE     = 2'd2,
        ST_HOLD_OFF  = 2'd3
    } wake_state_e;

    typedef struct packed {
        logic xtal_small;
        logic force_on;
        logic force_off;
        logic remember;
    } wake_cfg_t;

endpackage

// File: rtl/swk_cfg_reg.sv
module swk_cfg_reg
    import swk_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  logic         clk,
    input  logic         batt_rst_n,
    input  logic         host_wr,
    input  logic [W-1:0] host_wdata,
    output logic [W-1:0] host_rdata,
    output wake_cfg_t    cfg,
    output logic         cfg_conflict
);

    logic [W-1:0] cfg_q;
    logic         conflict_q;

    // Only the implemented bits get storage; reserved bits are tied low.
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (KEEP_MASK[i]) begin : g_store
            always_ff @(posedge clk or negedge batt_rst_n) begin
                if (!batt_rst_n) begin
                    cfg_q[i] <= 1'b0;
                end else if (host_wr) begin
                    cfg_q[i] <= host_wdata[i];
                end
            end
        end else begin : g_tie
            assign cfg_q[i] = 1'b0;
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^(host_wdata & ~KEEP_MASK);

    // The conflict flag is sticky; only the battery reset clears it.
    always_ff @(posedge clk or negedge batt_rst_n) begin
        if (!batt_rst_n) begin
            conflict_q <= 1'b0;
        end else if (host_wr && host_wdata[OFF_BIT] && host_wdata[ON_BIT]) begin
            conflict_q <= 1'b1;
        end
    end

    assign host_rdata       = cfg_q;
    assign cfg.remember     = cfg_q[REM_BIT];
    assign cfg.force_off    = cfg_q[OFF_BIT];
    assign cfg.force_on     = cfg_q[ON_BIT];
    assign cfg.xtal_small   = cfg_q[XTAL_BIT];
    assign cfg_conflict     = conflict_q;

endmodule

// File: rtl/swk_alarm_latch.sv
module swk_alarm_latch (
    input  logic clk,
    input  logic batt_rst_n,
    input  logic alarm2_hit,
    input  logic stby_present,
    input  logic remember_en,
    input  logic host_clear,
    input  logic wake_acked,
    output logic pending
);

    logic set_ev;
    logic clr_ev;

    assign set_ev = alarm2_hit && !stby_present && remember_en;
    assign clr_ev = host_clear || wake_acked;

    // Clearing wins over a new alarm in the same cycle.
    always_ff @(posedge clk or negedge batt_rst_n) begin
        if (!batt_rst_n) begin
            pending <= 1'b0;
        end else if (clr_ev) begin
            pending <= 1'b0;
        end else if (set_ev) begin
            pending <= 1'b1;
        end
    end

endmodule

// File: rtl/swk_seq_fsm.sv
module swk_seq_fsm
    import swk_pkg::*;
(
    input  logic        clk,
    input  logic        batt_rst_n,
    input  logic        stby_present,
    input  logic        stby_por,
    input  logic        main_pwr_good,
    input  logic        host_wr,
    input  logic        pending,
    input  wake_cfg_t   cfg,
    output logic        in_drive,
    output logic        pwr_on_drive
);

    wake_state_e state_q;
    wake_state_e state_d;

    always_ff @(posedge clk or negedge batt_rst_n) begin
        if (!batt_rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (stby_por && cfg.force_off) begin
            state_d = ST_HOLD_OFF;                  // force_off
        end else if (stby_por && cfg.force_on) begin
            state_d = ST_DRIVE;                     // force_on
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (pending && stby_present) begin
                        state_d = ST_DRIVE;         // wake
                    end else if (pending) begin
                        state_d = ST_WAIT_STBY;     // arm
                    end
                end
                ST_WAIT_STBY: begin
                    if (!pending) begin
                        state_d = ST_IDLE;          // abort
                    end else if (stby_present) begin
                        state_d = ST_DRIVE;         // wake
                    end
                end
                ST_DRIVE: begin
                    if (main_pwr_good) begin
                        state_d = ST_IDLE;          // ack
                    end
                end
                ST_HOLD_OFF: begin
                    if (!stby_present || host_wr) begin
                        state_d = ST_IDLE;          // unhold
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge batt_rst_n) begin
        if (!batt_rst_n) begin
            pwr_on_drive <= 1'b0;
        end else begin
            pwr_on_drive <= (state_d == ST_DRIVE);
        end
    end

    assign in_drive = (state_q == ST_DRIVE);

endmodule

// File: rtl/standby_wake_ctrl.sv
module standby_wake_ctrl
    import swk_pkg::*;
(
    input  logic             clk,
    input  logic             batt_rst_n,
    input  logic             stby_present,
    input  logic             stby_por,
    input  logic             alarm2_hit,
    input  logic             main_pwr_good,
    input  logic             host_wr,
    input  logic [CFG_W-1:0] host_wdata,
    output logic [CFG_W-1:0] host_rdata,
    output logic             pwr_on_drive,
    output logic             alarm_pending,
    output logic             cfg_conflict
);

    wake_cfg_t cfg;
    logic      in_drive;
    logic      host_clear;
    logic      wake_acked;
    logic      unused_xtal;

    assign unused_xtal = cfg.xtal_small;

    swk_cfg_reg #(.W(CFG_W)) u_cfg (
        .clk          (clk),
        .batt_rst_n   (batt_rst_n),
        .host_wr      (host_wr),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .cfg          (cfg),
        .cfg_conflict (cfg_conflict)
    );

    assign host_clear = host_wr && !host_wdata[REM_BIT];
    assign wake_acked = in_drive && main_pwr_good;

    swk_alarm_latch u_latch (
        .clk          (clk),
        .batt_rst_n   (batt_rst_n),
        .alarm2_hit   (alarm2_hit),
        .stby_present (stby_present),
        .remember_en  (cfg.remember),
        .host_clear   (host_clear),
        .wake_acked   (wake_acked),
        .pending      (alarm_pending)
    );

    swk_seq_fsm u_fsm (
        .clk           (clk),
        .batt_rst_n    (batt_rst_n),
        .stby_present  (stby_present),
        .stby_por      (stby_por),
        .main_pwr_good (main_pwr_good),
        .host_wr       (host_wr),
        .pending       (alarm_pending),
        .cfg           (cfg),
        .in_drive      (in_drive),
        .pwr_on_drive  (pwr_on_drive)
    );

endmodule

// File: rtl/standby_wake_ctrl_chk.sv
module standby_wake_ctrl_chk (
    input logic       clk,
    input logic       batt_rst_n,
    input logic       stby_present,
    input logic       stby_por,
    input logic       alarm2_hit,
    input logic       main_pwr_good,
    input logic       host_wr,
    input logic [7:0] host_wdata,
    input logic [7:0] host_rdata,
    input logic       pwr_on_drive,
    input logic       alarm_pending,
    input logic       cfg_conflict
);

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!batt_rst_n)
        host_rdata[6:3] == 4'b0000);

    a_r3_alarm_recorded: assert property (@(posedge clk) disable iff (!batt_rst_n)
        (alarm2_hit && !stby_present && host_rdata[0] && !host_wr &&
         !(pwr_on_drive && main_pwr_good)) |=> alarm_pending);

    a_r5_release_on_good: assert property (@(posedge clk) disable iff (!batt_rst_n)
        (pwr_on_drive && main_pwr_good && !stby_por) |=> !pwr_on_drive);

    a_r7_force_on: assert property (@(posedge clk) disable iff (!batt_rst_n)
        (stby_por && host_rdata[2] && !host_rdata[1]) |=> pwr_on_drive);

    a_r8_force_off: assert property (@(posedge clk) disable iff (!batt_rst_n)
        (stby_por && host_rdata[1]) |=> !pwr_on_drive);

    a_r9_conflict_sticky: assert property (@(posedge clk) disable iff (!batt_rst_n)
        cfg_conflict |=> cfg_conflict);

    a_r10_por_keeps_reg: assert property (@(posedge clk) disable iff (!batt_rst_n)
        (stby_por && !host_wr) |=> $stable(host_rdata));

endmodule

bind standby_wake_ctrl standby_wake_ctrl_chk u_chk (
    .clk           (clk),
    .batt_rst_n    (batt_rst_n),
    .stby_present  (stby_present),
    .stby_por      (stby_por),
    .alarm2_hit    (alarm2_hit),
    .main_pwr_good (main_pwr_good),
    .host_wr       (host_wr),
    .host_wdata    (host_wdata),
    .host_rdata    (host_rdata),
    .pwr_on_drive  (pwr_on_drive),
    .alarm_pending (alarm_pending),
    .cfg_conflict  (cfg_conflict)
);

// File: tb/standby_wake_ctrl_bench.sv
module standby_wake_ctrl_bench;

    localparam time CLK_PERIOD = 10ns;
    localparam int  N_VEC      = 34;
    localparam int  WATCHDOG   = 200000;

    // {stby,por,alarm,pg,wr}[27:23] wdata[22:15] {drv,pend,conf}[14:12] rdata[11:4] req[3:0]
    localparam logic [27:0] VEC [0:N_VEC-1] = '{
        {5'b10001, 8'hF9, 3'b000, 8'h81, 4'd2},  // R2 reserved bits drop
        {5'b10100, 8'h00, 3'b000, 8'h81, 4'd3},  // R3 alarm with standby present
        {5'b00000, 8'h00, 3'b000, 8'h81, 4'd3},  // R3
        {5'b00100, 8'h00, 3'b010, 8'h81, 4'd3},  // R3 alarm recorded
        {5'b00000, 8'h00, 3'b010, 8'h81, 4'd4},  // R4 waiting, no drive
        {5'b00000, 8'h00, 3'b010, 8'h81, 4'd4},  // R4
        {5'b10000, 8'h00, 3'b110, 8'h81, 4'd4},  // R4 standby back, drive
        {5'b10000, 8'h00, 3'b110, 8'h81, 4'd5},  // R5 hold until good
        {5'b10010, 8'h00, 3'b000, 8'h81, 4'd5},  // R5 ack releases and clears
        {5'b10000, 8'h00, 3'b000, 8'h81, 4'd5},  // R5
        {5'b00100, 8'h00, 3'b010, 8'h81, 4'd3},  // R3
        {5'b00000, 8'h00, 3'b010, 8'h81, 4'd4},  // R4
        {5'b00001, 8'h80, 3'b000, 8'h80, 4'd6},  // R6 host clears remember
        {5'b10000, 8'h00, 3'b000, 8'h80, 4'd6},  // R6 no wake on return
        {5'b10000, 8'h00, 3'b000, 8'h80, 4'd11}, // R11 bit 7 set, idle
        {5'b00100, 8'h00, 3'b000, 8'h80, 4'd3},  // R3 remember disabled
        {5'b11000, 8'h00, 3'b000, 8'h80, 4'd12}, // R12 reset with no policy
        {5'b10001, 8'h04, 3'b000, 8'h04, 4'd7},  // R7 setup
        {5'b11000, 8'h00, 3'b100, 8'h04, 4'd7},  // R7 force on
        {5'b10000, 8'h00, 3'b100, 8'h04, 4'd7},  // R7
        {5'b10010, 8'h00, 3'b000, 8'h04, 4'd5},  // R5
        {5'b10001, 8'h03, 3'b000, 8'h03, 4'd8},  // R8 setup
        {5'b00100, 8'h00, 3'b010, 8'h03, 4'd3},  // R3
        {5'b00000, 8'h00, 3'b010, 8'h03, 4'd4},  // R4
        {5'b11000, 8'h00, 3'b010, 8'h03, 4'd10}, // R10 record kept over reset
        {5'b10000, 8'h00, 3'b010, 8'h03, 4'd8},  // R8 held off
        {5'b10000, 8'h00, 3'b010, 8'h03, 4'd8},  // R8
        {5'b00000, 8'h00, 3'b010, 8'h03, 4'd8},  // R8 standby lost, unhold
        {5'b00000, 8'h00, 3'b010, 8'h03, 4'd4},  // R4
        {5'b10000, 8'h00, 3'b110, 8'h03, 4'd4},  // R4 wake
        {5'b11000, 8'h00, 3'b010, 8'h03, 4'd8},  // R8 release while driving
        {5'b10001, 8'h01, 3'b010, 8'h01, 4'd8},  // R8 host write unholds
        {5'b10000, 8'h00, 3'b110, 8'h01, 4'd8},  // R8 held record wakes
        {5'b10010, 8'h00, 3'b000, 8'h01, 4'd5}   // R5
    };

    logic       clk = 1'b0;
    logic       batt_rst_n;
    logic       stby_present;
    logic       stby_por;
    logic       alarm2_hit;
    logic       main_pwr_good;
    logic       host_wr;
    logic [7:0] host_wdata;
    logic [7:0] host_rdata;
    logic       pwr_on_drive;
    logic       alarm_pending;
    logic       cfg_conflict;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    standby_wake_ctrl u_standby_wake_ctrl (
        .clk           (clk),
        .batt_rst_n    (batt_rst_n),
        .stby_present  (stby_present),
        .stby_por      (stby_por),
        .alarm2_hit    (alarm2_hit),
        .main_pwr_good (main_pwr_good),
        .host_wr       (host_wr),
        .host_wdata    (host_wdata),
        .host_rdata    (host_rdata),
        .pwr_on_drive  (pwr_on_drive),
        .alarm_pending (alarm_pending),
        .cfg_conflict  (cfg_conflict)
    );

    task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {drv,pend,conf,rdata} actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [10:0] outs();
        return {pwr_on_drive, alarm_pending, cfg_conflict, host_rdata};
    endfunction

    // Drive inputs at the falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic step(input logic [4:0] ctl, input logic [7:0] wd);
        {stby_present, stby_por, alarm2_hit, main_pwr_good, host_wr} = ctl;
        host_wdata = wd;
        @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        batt_rst_n = 1'b0;
        {stby_present, stby_por, alarm2_hit, main_pwr_good, host_wr} = '0;
        host_wdata = '0;
        repeat (2) @(negedge clk);
        check("R1 reset state", outs(), 11'b0);
        batt_rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < N_VEC; i++) begin
            step(VEC[i][27:23], VEC[i][22:15]);
            check($sformatf("R%0d row %0d", VEC[i][3:0], i), outs(), VEC[i][14:4]);
        end

        // R9: both policies set -> conflict flag on the write edge
        step(5'b10001, 8'h06);
        check("R9 conflict set", outs(), {3'b001, 8'h06});
        // R9: force-on first, then a reset under conflict must release
        step(5'b10001, 8'h04);
        step(5'b11000, 8'h00);
        check("R7 drive before conflict reset", outs(), {3'b101, 8'h04});
        step(5'b10001, 8'h06);
        step(5'b11000, 8'h00);
        check("R9 keep-off wins", outs(), {3'b001, 8'h06});
        step(5'b10001, 8'h00);
        check("R9 conflict sticky", outs(), {3'b001, 8'h00});
        // R11: crystal bit alone with an alarm during loss does nothing
        step(5'b10001, 8'h80);
        step(5'b00100, 8'h00);
        check("R11 crystal bit inert", outs(), {3'b001, 8'h80});

        // R1: battery reset clears everything including the sticky flag
        batt_rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset after use", outs(), 11'b0);
        batt_rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule